// File: doc/BRIEF.md
# Secondary watchdog interrupt timer

This block is a short-range safety timer that sits beside a periodic interrupt source. It counts down an 8-bit period, one step per pulse of a slow timebase tick (a one-cycle strobe derived from a 32 kHz reference). If software stops servicing it, the count runs out and the block raises an interrupt request at a fixed, highest priority level. Software keeps it quiet by restarting it from inside the periodic handler.

Software sees two write ports. A write to the period port stores the period, loads the counter and arms the timer. Arming is one-way: only a reset disarms it. A write of the restart code to the shared watchdog command port reloads the counter from the stored period. Either action withdraws a pending request. Every reset source leaves the timer disarmed. This includes a reset caused by the primary watchdog.

A period of N gives a timeout of N ticks, and a period of 0 stands for 256 ticks. With a 32 kHz tick, the range runs from about 30.5 µs up to about 7.8 ms. A period of 0x40 gives about 1.95 ms.

Top module: `swd_timer`

## Requirements
- R1: After reset the timer is disarmed (`running_o` = 0) and `irq_o` = 0. While disarmed, ticks never raise the request.
- R2: A write to the period port with value N (1..255) arms the timer and clears `irq_o`. `irq_o` then stays 0 for the next N-1 ticks. It is 1 in the cycle after the clock edge that takes the N-th tick.
- R3: A period write of 0 behaves as a period of 256 ticks.
- R4: Cycles with `tick_i` = 0 do not advance the count, however many of them pass.
- R5: Once raised, `irq_o` stays 1 and further ticks have no effect until a period write or a restart.
- R6: A period write while a request is pending clears `irq_o` in the next cycle and starts a new full period of the new value.
- R7: A command-port write of the code 0x5F while armed clears `irq_o` and reloads the counter from the last written period. This applies both mid-count and while a request is pending.
- R8: A command-port write of any value other than 0x5F has no effect. A write of 0x5F while disarmed has no effect: the timer stays disarmed with `irq_o` = 0.
- R9: `irq_prio_o` always reads 3, the highest priority level.
- R10: A period write takes precedence over a tick and over a restart in the same cycle. The count starts as a full period of the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, any source |
| tick_i | input | 1 | One-cycle timebase strobe (32 kHz rate) |
| period_we_i | input | 1 | Period port write strobe |
| period_i | input | 8 | Period value, 0 meaning 256 ticks |
| cmd_we_i | input | 1 | Shared watchdog command port write strobe |
| cmd_i | input | 8 | Command byte; 0x5F restarts this timer |
| irq_o | output | 1 | Interrupt request, level, held until cleared |
| irq_prio_o | output | 2 | Fixed priority of the request (3) |
| running_o | output | 1 | Timer armed |

## Verification
The assertions take for granted that `tick_i` is a single-cycle strobe sampled synchronously. They also assume the write strobes may coincide with a tick or with each other, and that the precedence rule alone settles such cycles. The stimulus drives every input at the falling clock edge and holds each strobe for exactly one cycle. It makes same-cycle collisions deliberately and only in the precedence cases. Every other tick is followed by an idle cycle, so that the idle path is exercised all the time.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [1:0] {
    SWD_CMD_NONE    = 2'd0,
    SWD_CMD_LOAD    = 2'd1,
    SWD_CMD_RESTART = 2'd2
  } swd_cmd_e;

  localparam int          SWD_PRIO_W = 2;
  localparam logic [1:0]  SWD_PRIO   = 2'd3;
endpackage

// File: rtl/swd_cmd_decode.sv
module swd_cmd_decode
  import swd_pkg::*;
#(
  parameter int                CMD_W        = 8,
  parameter logic [CMD_W-1:0]  RESTART_CODE = 8'h5F
) (
  input  logic             period_we_i,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             armed_i,
  output swd_cmd_e         cmd_o
);
  logic restart_hit;

  assign restart_hit = cmd_we_i && (cmd_i == RESTART_CODE) && armed_i;

  always_comb begin
    if (period_we_i)      cmd_o = SWD_CMD_LOAD;
    else if (restart_hit) cmd_o = SWD_CMD_RESTART;
    else                  cmd_o = SWD_CMD_NONE;
  end
endmodule

// File: rtl/swd_counter.sv
module swd_counter
  import swd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  swd_cmd_e         cmd_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             tick_i,
  output logic             armed_o,
  output logic             expire_o,
  output logic [CNT_W:0]   count_o
);
  localparam logic [CNT_W:0] FULL_SPAN = (CNT_W+1)'(1) << CNT_W;

  function automatic logic [CNT_W:0] ticks_for(input logic [CNT_W-1:0] v);
    return (v == '0) ? FULL_SPAN : {1'b0, v};
  endfunction

  logic [CNT_W-1:0] period_q;
  logic [CNT_W:0]   cnt_q;
  logic             armed_q;
  logic             step_ev;

  assign step_ev  = (cmd_i == SWD_CMD_NONE) && armed_q && tick_i && (cnt_q != '0);
  assign expire_o = step_ev && (cnt_q == (CNT_W+1)'(1));
  assign armed_o  = armed_q;
  assign count_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      period_q <= '0;
    end else begin
      case (cmd_i)
        SWD_CMD_LOAD: begin
          period_q <= period_i;
          cnt_q    <= ticks_for(period_i);
          armed_q  <= 1'b1;
        end
        SWD_CMD_RESTART: cnt_q <= ticks_for(period_q);
        default: if (step_ev) cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  // R3: count never exceeds the 256-tick span
  p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_SPAN);
  // R2: one step down per accepted tick
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == SWD_CMD_NONE && armed_q && tick_i && cnt_q != '0)
      |=> cnt_q == $past(cnt_q) - 1'b1);
  // R4: idle cycles leave the count alone
  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == SWD_CMD_NONE && !tick_i) |=> $stable(cnt_q));
  // R5: zero is sticky without a command
  p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == SWD_CMD_NONE && cnt_q == '0) |=> cnt_q == '0);
  // R10: a load always yields a nonzero full period
  p_load_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == SWD_CMD_LOAD) |=> (cnt_q != '0 && armed_q));
  // R1: disarmed implies idle count
  p_disarmed_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> cnt_q == '0);
endmodule

// File: rtl/swd_irq_flag.sv
module swd_irq_flag
  import swd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  swd_cmd_e cmd_i,
  input  logic     expire_i,
  output logic     irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      irq_q <= 1'b0;
    else if (cmd_i != SWD_CMD_NONE)  irq_q <= 1'b0;
    else if (expire_i)               irq_q <= 1'b1;
  end

  assign irq_o = irq_q;

  // R6/R7: any load or restart withdraws the request
  p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i != SWD_CMD_NONE) |=> !irq_q);
  // R5: request held while no command arrives
  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && cmd_i == SWD_CMD_NONE) |=> irq_q);
  // R2: request rises only from an expiry event
  p_irq_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(expire_i));
endmodule

// File: rtl/swd_timer.sv
module swd_timer
  import swd_pkg::*;
#(
  parameter int               CNT_W        = 8,
  parameter int               CMD_W        = 8,
  parameter logic [CMD_W-1:0] RESTART_CODE = 8'h5F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  period_we_i,
  input  logic [CNT_W-1:0]      period_i,
  input  logic                  cmd_we_i,
  input  logic [CMD_W-1:0]      cmd_i,
  output logic                  irq_o,
  output logic [SWD_PRIO_W-1:0] irq_prio_o,
  output logic                  running_o
);
  swd_cmd_e       cmd_w;
  logic           armed_w;
  logic           expire_w;
  logic [CNT_W:0] count_w;

  swd_cmd_decode #(.CMD_W(CMD_W), .RESTART_CODE(RESTART_CODE)) u_dec (
    .period_we_i (period_we_i),
    .cmd_we_i    (cmd_we_i),
    .cmd_i       (cmd_i),
    .armed_i     (armed_w),
    .cmd_o       (cmd_w)
  );

  swd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd_w),
    .period_i (period_i),
    .tick_i   (tick_i),
    .armed_o  (armed_w),
    .expire_o (expire_w),
    .count_o  (count_w)
  );

  swd_irq_flag u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd_w),
    .expire_i (expire_w),
    .irq_o    (irq_o)
  );

  assign irq_prio_o = SWD_PRIO;
  assign running_o  = armed_w;

  // R8: no request can exist while disarmed
  p_irq_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> running_o);
  // R5: a pending request means the count sits at zero
  p_irq_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> count_w == '0);
  // R8: a non-restart command byte alone changes nothing
  p_foreign_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && cmd_i != RESTART_CODE && !period_we_i && !tick_i)
      |=> ($stable(count_w) && $stable(irq_o)));
endmodule

// File: tb/swd_timer_test.sv
module swd_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       period_we_i = 1'b0;
  logic [7:0] period_i = 8'h00;
  logic       cmd_we_i = 1'b0;
  logic [7:0] cmd_i = 8'h00;
  logic       irq_o;
  logic [1:0] irq_prio_o;
  logic       running_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  swd_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .period_we_i(period_we_i), .period_i(period_i),
    .cmd_we_i(cmd_we_i), .cmd_i(cmd_i),
    .irq_o(irq_o), .irq_prio_o(irq_prio_o), .running_o(running_o)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // one cycle of stimulus, then back to idle; returns at a falling edge
  task automatic drive(input logic pwe, input logic [7:0] pv,
                       input logic cwe, input logic [7:0] cv, input logic tk);
    @(negedge clk);
    period_we_i = pwe; period_i = pv; cmd_we_i = cwe; cmd_i = cv; tick_i = tk;
    @(negedge clk);
    period_we_i = 1'b0; cmd_we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
      @(negedge clk);
    end
  endtask

  task automatic wr_period(input logic [7:0] v);
    drive(1'b1, v, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic wr_cmd(input logic [7:0] v);
    drive(1'b0, 8'h00, 1'b1, v, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset irq", irq_o, 0);
    check("R1 reset running", running_o, 0);
    check("R9 prio", irq_prio_o, 3);
    ticks(5);
    check("R1 ticks while disarmed", irq_o, 0);
    wr_cmd(8'h5F);
    ticks(300);
    check("R8 restart while disarmed running", running_o, 0);
    check("R8 restart while disarmed irq", irq_o, 0);

    // R2/R3 sweep over every period value
    for (int p = 1; p <= 256; p++) begin
      wr_period(8'(p % 256));
      check("R2 armed after write", running_o, 1);
      check("R6 irq clear after write", irq_o, 0);
      ticks(p - 1);
      check(p == 256 ? "R3 before last tick" : "R2 before last tick", irq_o, 0);
      ticks(1);
      check(p == 256 ? "R3 on last tick" : "R2 on last tick", irq_o, 1);
      if (p % 32 == 0) begin
        ticks(3);
        check("R5 held after extra ticks", irq_o, 1);
      end
    end
    check("R9 prio while pending", irq_prio_o, 3);

    // R4: idle cycles do not count
    wr_period(8'd3);
    repeat (40) @(negedge clk);
    ticks(2);
    check("R4 idle cycles ignored", irq_o, 0);
    ticks(1);
    check("R4 third tick expires", irq_o, 1);

    // R7: restart while pending, 0x40 period
    wr_period(8'h40);
    ticks(64);
    check("R2 0x40 expiry", irq_o, 1);
    wr_cmd(8'h5E);
    check("R8 foreign code keeps irq", irq_o, 1);
    wr_cmd(8'h5F);
    check("R7 restart clears irq", irq_o, 0);
    ticks(63);
    check("R7 reload from stored period low", irq_o, 0);
    ticks(1);
    check("R7 reload from stored period high", irq_o, 1);

    // R7: restart mid-count
    wr_period(8'd10);
    ticks(6);
    wr_cmd(8'h5F);
    ticks(9);
    check("R7 mid-count restart low", irq_o, 0);
    ticks(1);
    check("R7 mid-count restart high", irq_o, 1);

    // R8: foreign code mid-count does not restart
    wr_period(8'd10);
    ticks(6);
    wr_cmd(8'hA0);
    ticks(4);
    check("R8 foreign code no restart", irq_o, 1);

    // R6: new period while pending
    wr_period(8'd4);
    check("R6 clear on new period", irq_o, 0);
    ticks(3);
    check("R6 new period low", irq_o, 0);
    ticks(1);
    check("R6 new period high", irq_o, 1);

    // R10: write with tick in the same cycle
    drive(1'b1, 8'd5, 1'b0, 8'h00, 1'b1);
    ticks(4);
    check("R10 write beats tick low", irq_o, 0);
    ticks(1);
    check("R10 write beats tick high", irq_o, 1);
    // R10: write with restart in the same cycle (stored 5, new 7)
    drive(1'b1, 8'd7, 1'b1, 8'h5F, 1'b0);
    ticks(6);
    check("R10 write beats restart low", irq_o, 0);
    ticks(1);
    check("R10 write beats restart high", irq_o, 1);

    // R1: reset disarms an armed timer
    wr_period(8'd2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    ticks(5);
    check("R1 reset disarms running", running_o, 0);
    check("R1 reset disarms irq", irq_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule